// File: doc/BRIEF.md
# Ancillary VBI Packet Formatter

This block takes the sliced vertical-blanking payload of one video line and wraps it in an ancillary packet. It sends the packet on the 8-bit luma path during horizontal blanking. When the video output path signals that an end-of-active-video code has just gone out, the block latches a descriptor of the line. The descriptor holds the payload length, field, whether the line lies inside vertical blanking, the 10-bit line number, the 6-bit service format and three quality flags. From the next clock on, the block streams an 8-byte header, the payload, a checksum and zero fill. A downstream multiplexer selects this stream whenever `anc_valid` is high.

The payload arrives on a valid/ready stream. The formatter raises `pl_ready` only in the cycles where a payload byte leaves on the output, one byte per cycle, and the byte passes straight through to the output. The output runs in lock-step with the line timing and has no back-pressure, so the source must hold `pl_valid` high whenever `pl_ready` is high. The formatter never waits for the source. If a packet would not fit in the blanking window, the block emits nothing for that line and pulses `ovf_pulse` instead.

Top module: `anc_vbi_packer`

## Requirements
- R1: The bytes at positions 0, 1 and 2 of every packet are 00h, FFh and FFh.
- R2: The bytes at positions 3, 4 and 5 carry a 6-bit value in bits [5:0]. Bit 6 is the even parity of bits [5:0], so bit 6 equals their XOR. Bit 7 is the inverse of bit 6.
- R3: The byte at position 3 is 91h for field 1 inside vertical blanking and 53h for field 1 outside it. It is 55h for field 2 inside vertical blanking and 97h for field 2 outside it. Field 2 is `field2`=1; inside vertical blanking is `in_vbi`=1.
- R4: Position 4 carries the service format `svc_fmt`. Position 5 carries the word count N = ceil((L+1)/4), where L is the payload length.
- R5: Position 6 is `line_num[7:0]`. Position 7 holds `line_num[9:8]` in bits [1:0], `match2` in bit 2, `match1` in bit 3 and `edc_err` in bit 4. Bits [7:5] are zero.
- R6: The L payload bytes appear in order at positions 8 to 7+L. `pl_ready` is high in exactly those cycles, so exactly L bytes are taken from the source.
- R7: Position 8+L is the 8-bit modulo sum of the L payload bytes.
- R8: Positions after the checksum are 00h. The packet length is 4·(N+2) bytes, which is a multiple of 4 and ends at byte 4N+7.
- R9: Byte 0 appears in the cycle right after the cycle in which `eav_done` and `pkt_req` are sampled high. `anc_valid` then stays high without a gap for the whole packet and drops right after it.
- R10: The block does not start a packet longer than `BLANK_SLOTS` bytes, or one with L > `MAX_LEN`. Instead, `ovf_pulse` is high for exactly one cycle, the cycle after the strobe, and `anc_valid` stays low.
- R11: An `eav_done` strobe while a packet is in flight, or a strobe with `pkt_req` low, does not change the output.
- R12: After reset, `anc_valid`, `pl_ready` and `ovf_pulse` are low and `anc_data` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eav_done | input | 1 | One-cycle strobe: the end-of-active-video code has just been sent |
| pkt_req | input | 1 | The current line has sliced data to send |
| pl_len | input | 8 | Payload length L in bytes |
| field2 | input | 1 | 1 = second field |
| in_vbi | input | 1 | 1 = line lies inside vertical blanking |
| line_num | input | 10 | Video line number |
| svc_fmt | input | 6 | Service format of the line |
| edc_err | input | 1 | A single error was detected in the block |
| match1 | input | 1 | Match flag 1 |
| match2 | input | 1 | Match flag 2 |
| pl_valid | input | 1 | Payload byte available |
| pl_ready | output | 1 | Payload byte is consumed this cycle |
| pl_data | input | 8 | Payload byte |
| anc_valid | output | 1 | Packet byte on `anc_data` |
| anc_data | output | 8 | Packet byte stream |
| ovf_pulse | output | 1 | Packet did not fit in the blanking window |

## Verification
The bench builds the block with `BLANK_SLOTS` = 64 and `MAX_LEN` = 251. With these values the fit limit falls at a payload of 55 bytes, so a sweep of every length from 0 to 60 covers every fill count, both sides of the overflow boundary and all four field/blanking combinations. Lengths of 2, 13 and 43 bytes are also run on their own. During the 13-byte run a second strobe is injected to show that a strobe mid-packet changes nothing.

// File: rtl/anc_pkt_pkg.sv
package anc_pkt_pkg;
  localparam int ANC_LEN_W = 8;

  typedef struct packed {
    logic [ANC_LEN_W-1:0] len;
    logic                 field2;
    logic                 in_vbi;
    logic [9:0]           line;
    logic [5:0]           fmt;
    logic                 err;
    logic                 m1;
    logic                 m2;
  } anc_ctx_t;

  // 6-bit value protected by even parity (bit 6) and its inverse (bit 7)
  function automatic logic [7:0] prot6(input logic [5:0] v);
    logic p;
    p = ^v;
    return {~p, p, v};
  endfunction

  // identifier: low bits 0x11, +2 when outside blanking, +4 for field 2
  function automatic logic [5:0] did6(input logic f2, input logic vbi);
    return {3'b010, f2, ~vbi, 1'b1};
  endfunction
endpackage

// File: rtl/anc_len_plan.sv
module anc_len_plan #(
  parameter int LEN_W       = 8,
  parameter int POS_W       = 9,
  parameter int BLANK_SLOTS = 268,
  parameter int MAX_LEN     = 251
) (
  input  logic [LEN_W-1:0] len,
  output logic [5:0]       words,
  output logic [POS_W-1:0] last_pos,
  output logic             fits
);
  int w_i;
  int total_i;

  always_comb begin
    w_i      = (int'(len) + 4) / 4;
    total_i  = (w_i + 2) * 4;
    words    = w_i[5:0];
    last_pos = POS_W'(total_i - 1);
    fits     = (int'(len) <= MAX_LEN) && (total_i <= BLANK_SLOTS);
  end
endmodule

// File: rtl/anc_seq.sv
module anc_seq #(
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [POS_W-1:0] last_pos,
  output logic             active,
  output logic [POS_W-1:0] pos,
  output logic             at_last
);
  assign at_last = active && (pos == last_pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      pos    <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        pos    <= '0;
      end
    end else if (at_last) begin
      active <= 1'b0;
    end else begin
      pos <= pos + 1'b1;
    end
  end

  // R9: no gap inside a packet, position steps by one
  a_r9_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    active && !at_last |=> active && (pos == $past(pos) + 1'b1));

  // R8: a packet always closes on the last byte of a 4-byte word
  a_r8_word_end: assert property (@(posedge clk) disable iff (!rst_n)
    at_last |-> pos[1:0] == 2'b11);
endmodule

// File: rtl/anc_byte_mux.sv
module anc_byte_mux
  import anc_pkt_pkg::*;
#(
  parameter int POS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic [POS_W-1:0] pos,
  input  anc_ctx_t         ctx,
  input  logic [5:0]       words,
  input  logic [7:0]       pl_data,
  output logic [7:0]       byte_out,
  output logic             pl_take
);
  localparam int HDR_BYTES = 8;

  logic [7:0]       csum;
  logic [POS_W-1:0] off;

  assign off = pos - POS_W'(HDR_BYTES);

  always_comb begin
    byte_out = 8'h00;
    pl_take  = 1'b0;
    if (pos < POS_W'(HDR_BYTES)) begin
      case (pos[2:0])
        3'd0:    byte_out = 8'h00;
        3'd1:    byte_out = 8'hFF;
        3'd2:    byte_out = 8'hFF;
        3'd3:    byte_out = prot6(did6(ctx.field2, ctx.in_vbi));
        3'd4:    byte_out = prot6(ctx.fmt);
        3'd5:    byte_out = prot6(words);
        3'd6:    byte_out = ctx.line[7:0];
        default: byte_out = {3'b000, ctx.err, ctx.m1, ctx.m2, ctx.line[9:8]};
      endcase
    end else if (off < POS_W'(ctx.len)) begin
      byte_out = pl_data;
      pl_take  = active;
    end else if (off == POS_W'(ctx.len)) begin
      byte_out = csum;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || start) csum <= 8'h00;
    else if (pl_take)    csum <= csum + pl_data;
  end

  // R7: checksum holds still outside the payload phase
  a_r7_csum_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_take && !start |=> $stable(csum));
endmodule

// File: rtl/anc_vbi_packer.sv
module anc_vbi_packer
  import anc_pkt_pkg::*;
#(
  parameter int BLANK_SLOTS = 268,
  parameter int MAX_LEN     = 251
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eav_done,
  input  logic       pkt_req,
  input  logic [7:0] pl_len,
  input  logic       field2,
  input  logic       in_vbi,
  input  logic [9:0] line_num,
  input  logic [5:0] svc_fmt,
  input  logic       edc_err,
  input  logic       match1,
  input  logic       match2,
  input  logic       pl_valid,
  output logic       pl_ready,
  input  logic [7:0] pl_data,
  output logic       anc_valid,
  output logic [7:0] anc_data,
  output logic       ovf_pulse
);
  localparam int POS_W = $clog2(4 * (63 + 2));

  logic             active, at_last, start, ask;
  logic [POS_W-1:0] pos, plan_last, last_q;
  logic [5:0]       plan_words, words_q;
  logic             plan_fits;
  logic [7:0]       body_byte;
  anc_ctx_t         ctx_q;

  anc_len_plan #(.LEN_W(ANC_LEN_W), .POS_W(POS_W),
                 .BLANK_SLOTS(BLANK_SLOTS), .MAX_LEN(MAX_LEN)) plan_i (
    .len(pl_len), .words(plan_words), .last_pos(plan_last), .fits(plan_fits));

  assign ask   = eav_done && pkt_req && !active;
  assign start = ask && plan_fits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_q     <= '0;
      words_q   <= '0;
      last_q    <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= ask && !plan_fits;
      if (start) begin
        ctx_q   <= '{len: pl_len, field2: field2, in_vbi: in_vbi, line: line_num,
                     fmt: svc_fmt, err: edc_err, m1: match1, m2: match2};
        words_q <= plan_words;
        last_q  <= plan_last;
      end
    end
  end

  anc_seq #(.POS_W(POS_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .last_pos(last_q),
    .active(active), .pos(pos), .at_last(at_last));

  anc_byte_mux #(.POS_W(POS_W)) mux_i (
    .clk(clk), .rst_n(rst_n), .start(start), .active(active), .pos(pos),
    .ctx(ctx_q), .words(words_q), .pl_data(pl_data),
    .byte_out(body_byte), .pl_take(pl_ready));

  assign anc_valid = active;
  assign anc_data  = active ? body_byte : 8'h00;

  // R10: an overflowing line never produces output
  a_r10_no_start_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> !anc_valid);

  // R11: latched descriptor is frozen while a packet is in flight
  a_r11_ctx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    active && $past(active) |-> $stable(ctx_q) && $stable(last_q));

  // R6: the source must have a byte whenever one is taken
  a_r6_src_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> pl_valid);

  // R6: bytes are only taken while a packet is on the output
  a_r6_take_in_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> anc_valid && !$past(at_last));
endmodule

// File: tb/anc_vbi_packer_tb.sv
module anc_vbi_packer_tb_top;
  localparam int BLANK = 64;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       eav_done = 0, pkt_req = 0, field2 = 0, in_vbi = 0;
  logic       edc_err = 0, match1 = 0, match2 = 0;
  logic [7:0] pl_len = 0;
  logic [9:0] line_num = 0;
  logic [5:0] svc_fmt = 0;
  logic       pl_ready, anc_valid, ovf_pulse;
  logic [7:0] anc_data, pl_data;
  logic [7:0] pmem [256];
  logic [7:0] pl_idx;
  logic       pl_clr = 0;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  anc_vbi_packer #(.BLANK_SLOTS(BLANK), .MAX_LEN(251)) dut_i (
    .clk(clk), .rst_n(rst_n), .eav_done(eav_done), .pkt_req(pkt_req),
    .pl_len(pl_len), .field2(field2), .in_vbi(in_vbi), .line_num(line_num),
    .svc_fmt(svc_fmt), .edc_err(edc_err), .match1(match1), .match2(match2),
    .pl_valid(1'b1), .pl_ready(pl_ready), .pl_data(pl_data),
    .anc_valid(anc_valid), .anc_data(anc_data), .ovf_pulse(ovf_pulse));

  assign pl_data = pmem[pl_idx];
  always @(posedge clk) begin
    if (pl_clr)        pl_idx <= 8'd0;
    else if (pl_ready) pl_idx <= pl_idx + 8'd1;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", rq, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pbyte(input logic [5:0] v);
    return {~(^v), ^v, v};
  endfunction

  task automatic run_pkt(input int len, input bit f2, input bit vbi, input int ln,
                         input int fmt, input bit e, input bit m1, input bit m2,
                         input bit poke);
    int nw, total, fits;
    logic [7:0] exp [260];
    logic [7:0] cs;
    nw = (len + 1 + 3) / 4;
    total = 4 * (nw + 2);
    fits = (total <= BLANK) && (len <= 251);
    cs = 0;
    for (int k = 0; k < len; k++) begin
      pmem[k] = 8'(k * 37 + len * 11 + 5);
      cs = cs + pmem[k];
    end
    for (int k = 0; k < total; k++) exp[k] = 8'h00;
    exp[1] = 8'hFF; exp[2] = 8'hFF;
    exp[3] = f2 ? (vbi ? 8'h55 : 8'h97) : (vbi ? 8'h91 : 8'h53);
    exp[4] = pbyte(6'(fmt));
    exp[5] = pbyte(6'(nw));
    exp[6] = 8'(ln);
    exp[7] = {3'b000, e, m1, m2, 2'(ln >> 8)};
    for (int k = 0; k < len; k++) exp[8 + k] = pmem[k];
    exp[8 + len] = cs;
    @(negedge clk); pl_clr = 1;
    @(negedge clk); pl_clr = 0;
    pl_len = 8'(len); field2 = f2; in_vbi = vbi; line_num = 10'(ln);
    svc_fmt = 6'(fmt); edc_err = e; match1 = m1; match2 = m2;
    eav_done = 1; pkt_req = 1;
    @(negedge clk); eav_done = 0;
    if (!fits) begin
      chk(ovf_pulse === 1'b1, "R10 pulse", ovf_pulse, 1);
      chk(anc_valid === 1'b0, "R10 no start", anc_valid, 0);
      @(negedge clk);
      chk(ovf_pulse === 1'b0, "R10 single pulse", ovf_pulse, 0);
      chk(anc_valid === 1'b0, "R10 idle", anc_valid, 0);
      return;
    end
    chk(ovf_pulse === 1'b0, "R10 no pulse on fit", ovf_pulse, 0);
    for (int k = 0; k < total; k++) begin
      string rq;
      rq = k < 3 ? "R1" : k == 3 ? "R3" : k < 6 ? "R4" : k < 8 ? "R5" :
           k < 8 + len ? "R6" : k == 8 + len ? "R7" : "R8";
      chk(anc_valid === 1'b1, "R9 valid", anc_valid, 1);
      chk(anc_data === exp[k], rq, anc_data, exp[k]);
      if (k >= 3 && k <= 5)
        chk(anc_data[6] == ^anc_data[5:0] && anc_data[7] == ~anc_data[6],
            "R2 parity", anc_data, exp[k]);
      if (poke && k == 4) begin
        eav_done = 1; pl_len = 8'd0; line_num = 10'h3FF; field2 = ~f2;
      end else begin
        eav_done = 0;
      end
      @(negedge clk);
    end
    eav_done = 0;
    chk(anc_valid === 1'b0, "R9 end", anc_valid, 0);
    chk(int'(pl_idx) == (len & 255), "R6 count", pl_idx, len);
    if (poke) chk(ovf_pulse === 1'b0, "R11 busy strobe", ovf_pulse, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 256; k++) pmem[k] = 8'h00;
    repeat (3) @(negedge clk);
    chk(anc_valid === 1'b0 && pl_ready === 1'b0, "R12 reset", anc_valid, 0);
    chk(ovf_pulse === 1'b0 && anc_data === 8'h00, "R12 reset", anc_data, 0);
    rst_n = 1;
    // R11: strobe without request produces nothing
    @(negedge clk); eav_done = 1; pkt_req = 0; pl_len = 8'd4;
    @(negedge clk); eav_done = 0;
    for (int k = 0; k < 3; k++) begin
      chk(anc_valid === 1'b0 && ovf_pulse === 1'b0, "R11 no request", anc_valid, 0);
      @(negedge clk);
    end
    run_pkt(2, 0, 1, 21, 7, 0, 1, 0, 0);
    run_pkt(13, 1, 0, 16, 12, 1, 0, 1, 1);
    run_pkt(43, 1, 1, 774, 1, 1, 1, 1, 0);
    for (int len = 0; len <= 60; len++)
      run_pkt(len, len[0], len[1], len * 17 + 3, len * 5, len[2], len[3], len[4], 0);
    run_pkt(200, 0, 0, 9, 3, 0, 0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule